// File: doc/BRIEF.md
# Daily Alarm Comparator with Wildcard Fields

This block decides when a real-time clock alarm goes off. A separate time counter advances the hours, minutes and seconds once per second and then pulses an update strobe. In that same cycle the block compares the three current time bytes with three programmed alarm bytes. When all three fields agree, it latches an alarm flag. It also raises a summary interrupt flag and an active-low interrupt line if alarm interrupts are enabled.

An alarm byte whose two top bits are both set is a wildcard, so any value from 0xC0 to 0xFF in that byte matches every value of its field. With a wildcard in the hours byte only, the alarm fires once per hour. With wildcards in hours and minutes, it fires once per minute. With wildcards in all three bytes, it fires on every update. With no wildcard, it fires once a day. Every other byte is compared exactly, bit for bit, in whatever coding the time counter uses. This includes the PM bit of a 12-hour hours byte.

The host reads the flags through an 8-bit status byte. The read strobe clears both flags at the clock edge that ends the read cycle. The status value shown during that cycle is the value from before the clear.

Top module: `alarm_match_unit`

## Requirements
- R1: After reset, alarm_flag and irq_flag are 0, irq_n is 1 and stat_q is 0x00.
- R2: When upd_stb is 1 and all three alarm bytes equal the current time bytes, alarm_flag is 1 from the next cycle.
- R3: Without upd_stb, a clear alarm_flag stays 0 even when the time and alarm bytes agree.
- R4: A difference in any single non-wildcard field at the update leaves alarm_flag at 0.
- R5: An alarm byte is a wildcard only when bits 7 and 6 are both 1 (0xC0 to 0xFF). Bytes with only one of these bits set, such as 0x80 or 0x40, are compared exactly.
- R6: A wildcard field matches any current value. Wildcards in hours give a match for every hour, wildcards in hours and minutes give a match for every minute, and three wildcards give a match on every update.
- R7: A match sets alarm_flag even while alm_ie is 0. In that case irq_flag stays 0 and irq_n stays 1.
- R8: One cycle after any change, irq_flag equals alarm_flag AND alm_ie, and irq_n is always its inverse.
- R9: stat_q carries irq_flag in bit 7 and alarm_flag in bit 5. All other bits read 0.
- R10: A cycle with stat_rd shows the pre-read flags on stat_q. From the next cycle, alarm_flag and irq_flag are 0, unless a match arrives in the same cycle.
- R11: When stat_rd and a matching update fall in the same cycle, the set wins and alarm_flag is 1 afterwards.
- R12: The PM bit (bit 7) of the hours byte takes part in the exact compare: 0x81 does not match 0x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_stb | input | 1 | One-cycle pulse after the time bytes have advanced |
| cur_hr | input | 8 | Current hours byte |
| cur_min | input | 8 | Current minutes byte |
| cur_sec | input | 8 | Current seconds byte |
| alm_hr | input | 8 | Alarm hours byte |
| alm_min | input | 8 | Alarm minutes byte |
| alm_sec | input | 8 | Alarm seconds byte |
| alm_ie | input | 1 | Alarm interrupt enable |
| stat_rd | input | 1 | Host read strobe for the status byte |
| stat_q | output | 8 | Status byte: bit 7 summary interrupt, bit 5 alarm |
| alarm_flag | output | 1 | Latched alarm flag |
| irq_flag | output | 1 | Summary interrupt flag |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The host read of the status byte and a matching once-per-second update can fall in the same cycle. In that case the clear and the set compete for the alarm flag. The bench first latches an alarm. It then drives stat_rd and a matching upd_stb together on one edge. It checks that stat_q showed the old flags during that cycle and that the flag is still set afterwards. It repeats the read with a non-matching update to show that the clear alone does take effect.

// File: rtl/alm_pkg.sv
package alm_pkg;
  // Status byte bit positions decoded by the host
  localparam int STAT_W       = 8;
  localparam int STAT_IRQ_BIT = 7;
  localparam int STAT_AF_BIT  = 5;
endpackage

// File: rtl/alm_field_cmp.sv
module alm_field_cmp #(
  parameter int W  = 8,
  parameter int WB = 2
) (
  input  logic [W-1:0] alm_byte,
  input  logic [W-1:0] cur_byte,
  output logic         hit
);
  logic wild;
  always_comb begin
    wild = &alm_byte[W-1 -: WB];
    hit  = wild | (alm_byte == cur_byte);
  end
endmodule

// File: rtl/alm_flag_ctl.sv
module alm_flag_ctl (
  input  logic clk,
  input  logic rst,
  input  logic set_req,
  input  logic clr_req,
  input  logic ie,
  output logic af,
  output logic irqf,
  output logic irq_n
);
  logic af_d;
  logic irq_d;
  always_comb begin
    // set has priority so an alarm arriving during a read is kept
    af_d  = set_req | (af & ~clr_req);
    irq_d = af_d & ie;
  end
  always_ff @(posedge clk) begin
    if (rst) begin
      af    <= 1'b0;
      irqf  <= 1'b0;
      irq_n <= 1'b1;
    end else begin
      af    <= af_d;
      irqf  <= irq_d;
      irq_n <= ~irq_d;
    end
  end
endmodule

// File: rtl/alarm_match_unit.sv
module alarm_match_unit #(
  parameter int FIELD_W = 8,
  parameter int WILD_W  = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               upd_stb,
  input  logic [FIELD_W-1:0] cur_hr,
  input  logic [FIELD_W-1:0] cur_min,
  input  logic [FIELD_W-1:0] cur_sec,
  input  logic [FIELD_W-1:0] alm_hr,
  input  logic [FIELD_W-1:0] alm_min,
  input  logic [FIELD_W-1:0] alm_sec,
  input  logic               alm_ie,
  input  logic               stat_rd,
  output logic [7:0]         stat_q,
  output logic               alarm_flag,
  output logic               irq_flag,
  output logic               irq_n
);
  import alm_pkg::*;
  localparam int NUM_F = 3;

  logic [FIELD_W-1:0] alm_v [NUM_F];
  logic [FIELD_W-1:0] cur_v [NUM_F];
  logic [NUM_F-1:0]   hit_v;
  logic               set_req;

  always_comb begin
    alm_v[0] = alm_sec; cur_v[0] = cur_sec;
    alm_v[1] = alm_min; cur_v[1] = cur_min;
    alm_v[2] = alm_hr;  cur_v[2] = cur_hr;
  end

  for (genvar i = 0; i < NUM_F; i++) begin : g_fld
    alm_field_cmp #(.W(FIELD_W), .WB(WILD_W)) u_cmp (
      .alm_byte (alm_v[i]),
      .cur_byte (cur_v[i]),
      .hit      (hit_v[i])
    );
  end

  assign set_req = upd_stb & (&hit_v);

  alm_flag_ctl u_flags (
    .clk     (clk),
    .rst     (rst),
    .set_req (set_req),
    .clr_req (stat_rd),
    .ie      (alm_ie),
    .af      (alarm_flag),
    .irqf    (irq_flag),
    .irq_n   (irq_n)
  );

  always_comb begin
    stat_q               = '0;
    stat_q[STAT_IRQ_BIT] = irq_flag;
    stat_q[STAT_AF_BIT]  = alarm_flag;
  end
endmodule

// File: rtl/alm_match_chk.sv
module alm_match_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         upd_stb,
  input logic         stat_rd,
  input logic         alm_ie,
  input logic [W-1:0] alm_hr,
  input logic [W-1:0] alm_min,
  input logic [W-1:0] alm_sec,
  input logic [7:0]   stat_q,
  input logic         alarm_flag,
  input logic         irq_flag,
  input logic         irq_n
);
  AST_NO_SET_WITHOUT_UPD: assert property (@(posedge clk) disable iff (rst)
    (!upd_stb && !alarm_flag) |=> !alarm_flag); // R3
  AST_ALL_WILD_FIRES: assert property (@(posedge clk) disable iff (rst)
    (upd_stb && (&alm_hr[W-1 -: 2]) && (&alm_min[W-1 -: 2]) && (&alm_sec[W-1 -: 2]))
    |=> alarm_flag); // R6
  AST_IE_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    !alm_ie |=> !irq_flag); // R7
  AST_IRQ_NEEDS_AF: assert property (@(posedge clk) disable iff (rst)
    irq_flag |-> alarm_flag); // R8
  AST_IRQ_PIN_INV: assert property (@(posedge clk) disable iff (rst)
    irq_n != irq_flag); // R8
  AST_STAT_ZERO_BITS: assert property (@(posedge clk) disable iff (rst)
    (stat_q[6] == 1'b0) && (stat_q[4:0] == 5'd0)); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !upd_stb) |=> (!alarm_flag && !irq_flag)); // R10
endmodule

bind alarm_match_unit alm_match_chk #(.W(FIELD_W)) u_chk (
  .clk(clk), .rst(rst), .upd_stb(upd_stb), .stat_rd(stat_rd), .alm_ie(alm_ie),
  .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec), .stat_q(stat_q),
  .alarm_flag(alarm_flag), .irq_flag(irq_flag), .irq_n(irq_n)
);

// File: tb/sim_alarm_match_unit.sv
module sim_alarm_match_unit;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic upd_stb = 1'b0, alm_ie = 1'b0, stat_rd = 1'b0;
  logic [7:0] cur_hr = 8'h00, cur_min = 8'h00, cur_sec = 8'h00;
  logic [7:0] alm_hr = 8'h00, alm_min = 8'h00, alm_sec = 8'h00;
  logic [7:0] stat_q;
  logic alarm_flag, irq_flag, irq_n;
  int n_run = 0, n_fail = 0;

  always #10 clk = ~clk;

  alarm_match_unit u0 (
    .clk(clk), .rst(rst), .upd_stb(upd_stb),
    .cur_hr(cur_hr), .cur_min(cur_min), .cur_sec(cur_sec),
    .alm_hr(alm_hr), .alm_min(alm_min), .alm_sec(alm_sec),
    .alm_ie(alm_ie), .stat_rd(stat_rd), .stat_q(stat_q),
    .alarm_flag(alarm_flag), .irq_flag(irq_flag), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_alarm(input logic [7:0] h, m, s);
    alm_hr = h; alm_min = m; alm_sec = s;
  endtask

  // one update pulse with the given time; returns at the negedge after the edge
  task automatic tick(input logic [7:0] h, m, s, input logic rd);
    @(negedge clk);
    cur_hr = h; cur_min = m; cur_sec = s; upd_stb = 1'b1; stat_rd = rd;
    @(negedge clk);
    upd_stb = 1'b0; stat_rd = 1'b0;
  endtask

  task automatic read_clear();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 af", {7'd0, alarm_flag}, 8'h00);
    check("R1 irqf", {7'd0, irq_flag}, 8'h00);
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 stat", stat_q, 8'h00);
  endtask

  task automatic t_daily();
    alm_ie = 1'b1;
    set_alarm(8'h12, 8'h34, 8'h56);
    tick(8'h12, 8'h34, 8'h55, 1'b0);
    check("R4 one second early", {7'd0, alarm_flag}, 8'h00);
    tick(8'h12, 8'h34, 8'h56, 1'b0);
    check("R2 daily match", {7'd0, alarm_flag}, 8'h01);
    check("R8 irqf set", {7'd0, irq_flag}, 8'h01);
    check("R8 irq_n low", {7'd0, irq_n}, 8'h00);
    @(negedge clk); stat_rd = 1'b1;
    #1 check("R9 R10 stat during read", stat_q, 8'hA0);
    @(negedge clk); stat_rd = 1'b0;
    check("R10 cleared af", {7'd0, alarm_flag}, 8'h00);
    check("R10 cleared stat", stat_q, 8'h00);
    check("R10 irq_n high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_no_update();
    set_alarm(8'h05, 8'h06, 8'h07);
    @(negedge clk);
    cur_hr = 8'h05; cur_min = 8'h06; cur_sec = 8'h07;
    repeat (4) @(negedge clk);
    check("R3 no strobe", {7'd0, alarm_flag}, 8'h00);
  endtask

  task automatic t_mismatch();
    set_alarm(8'h05, 8'h06, 8'h07);
    tick(8'h04, 8'h06, 8'h07, 1'b0);
    check("R4 hours differ", {7'd0, alarm_flag}, 8'h00);
    tick(8'h05, 8'h16, 8'h07, 1'b0);
    check("R4 minutes differ", {7'd0, alarm_flag}, 8'h00);
    tick(8'h05, 8'h06, 8'h17, 1'b0);
    check("R4 seconds differ", {7'd0, alarm_flag}, 8'h00);
  endtask

  task automatic t_pm();
    set_alarm(8'h81, 8'h00, 8'h00);
    tick(8'h01, 8'h00, 8'h00, 1'b0);
    check("R12 AM vs PM", {7'd0, alarm_flag}, 8'h00);
    tick(8'h81, 8'h00, 8'h00, 1'b0);
    check("R12 PM match", {7'd0, alarm_flag}, 8'h01);
    read_clear();
  endtask

  task automatic t_wild();
    set_alarm(8'hC0, 8'h10, 8'h20);
    tick(8'h07, 8'h10, 8'h20, 1'b0);
    check("R6 hourly hit", {7'd0, alarm_flag}, 8'h01);
    read_clear();
    tick(8'h23, 8'h11, 8'h20, 1'b0);
    check("R6 hourly wrong minute", {7'd0, alarm_flag}, 8'h00);
    set_alarm(8'hFF, 8'hD5, 8'h30);
    tick(8'h19, 8'h42, 8'h30, 1'b0);
    check("R6 minutely hit", {7'd0, alarm_flag}, 8'h01);
    read_clear();
    set_alarm(8'hC3, 8'hE1, 8'hFF);
    for (int k = 0; k < 3; k++) begin
      tick(8'(k * 7), 8'(k * 11), 8'(k * 13), 1'b0);
      check("R6 every second", {7'd0, alarm_flag}, 8'h01);
      read_clear();
    end
    set_alarm(8'h80, 8'h00, 8'h00);
    tick(8'h07, 8'h00, 8'h00, 1'b0);
    check("R5 0x80 not wildcard", {7'd0, alarm_flag}, 8'h00);
    set_alarm(8'h40, 8'h00, 8'h00);
    tick(8'h07, 8'h00, 8'h00, 1'b0);
    check("R5 0x40 not wildcard", {7'd0, alarm_flag}, 8'h00);
    set_alarm(8'h00, 8'h00, 8'hC0);
    tick(8'h00, 8'h00, 8'h3B, 1'b0);
    check("R5 0xC0 wildcard seconds", {7'd0, alarm_flag}, 8'h01);
    read_clear();
  endtask

  task automatic t_ie_off();
    alm_ie = 1'b0;
    set_alarm(8'h02, 8'h03, 8'h04);
    tick(8'h02, 8'h03, 8'h04, 1'b0);
    check("R7 af set with ie off", {7'd0, alarm_flag}, 8'h01);
    check("R7 irqf low", {7'd0, irq_flag}, 8'h00);
    check("R7 irq_n high", {7'd0, irq_n}, 8'h01);
    check("R7 R9 stat", stat_q, 8'h20);
    alm_ie = 1'b1;
    @(negedge clk);
    check("R8 irqf follows enable", {7'd0, irq_flag}, 8'h01);
    check("R8 irq_n follows enable", {7'd0, irq_n}, 8'h00);
    alm_ie = 1'b0;
    @(negedge clk);
    check("R8 irqf drops with enable", {7'd0, irq_flag}, 8'h00);
    alm_ie = 1'b1;
    read_clear();
  endtask

  task automatic t_collide();
    set_alarm(8'h09, 8'h09, 8'h09);
    tick(8'h09, 8'h09, 8'h09, 1'b0);
    check("R11 setup", {7'd0, alarm_flag}, 8'h01);
    @(negedge clk);
    cur_hr = 8'h09; cur_min = 8'h09; cur_sec = 8'h09; upd_stb = 1'b1; stat_rd = 1'b1;
    #1 check("R11 stat before edge", stat_q, 8'hA0);
    @(negedge clk); upd_stb = 1'b0; stat_rd = 1'b0;
    check("R11 set wins", {7'd0, alarm_flag}, 8'h01);
    check("R11 irqf kept", {7'd0, irq_flag}, 8'h01);
    tick(8'h09, 8'h09, 8'h0A, 1'b1);
    check("R10 read with missed update clears", {7'd0, alarm_flag}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_daily();
    t_no_update();
    t_mismatch();
    t_pm();
    t_wild();
    t_ie_off();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(20 * 200000);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule